// File: doc/BRIEF.md
# Stack Pointer Displacement Accumulator

This block sits between instruction decode and dispatch and takes the serial dependency out of chains of pushes, pops and frame-relative accesses. It holds an accelerated copy of the stack pointer and of the frame pointer. Each copy is a base value, a running signed displacement and a base epoch. Every cycle it accepts up to three decoded stack operations in slot order. Pushes, pops and explicit stack adjustments only move the displacement, so the base register is touched only when software writes a value that cannot be derived.

Each memory-touching operation leaves one cycle later with four fields: which pointer it is based on, the accelerated base value, its accumulated displacement and the epoch of that base. The address generator adds base and displacement. A copy of the stack pointer into the frame pointer, or the reverse, moves base, displacement and epoch together, so both pointers keep sharing one base. For every pair of slots the block also reports whether the two accesses are independent. This lets the load/store side reorder stack accesses before any address is computed.

A separate write port resynchronizes a pointer when its value has been computed by ordinary code.

Top module: `stack_disp_accum`

## Requirements
- R1: After reset, both displacements, both bases, both epochs and the epoch counter are zero. No access is valid and no pair is flagged independent.
- R2: A push (kind 1) first lowers the stack displacement by the data size. Its access displacement is the lowered value. The size code maps 0→2, 1→4, 2→8 and 3→8 bytes.
- R3: A pop (kind 2) accesses at the stack displacement before it moves, then raises the displacement by the data size.
- R4: Operations of one cycle are applied in slot order, slot 0 first. Each slot sees the effect of all lower slots. All results appear on the access outputs one clock after the operations are presented.
- R5: A stack-relative access (kind 3) or frame-relative access (kind 4) uses the current displacement of that pointer plus its signed immediate, and changes no pointer. Its size code is passed through unchanged.
- R6: A stack adjust (kind 5) adds its signed immediate to the stack displacement and produces no access.
- R7: Kind 6 copies the stack pointer's base, displacement and epoch into the frame pointer. Kind 7 copies the frame pointer's into the stack pointer. Neither produces an access.
- R8: A write on the resync port loads the chosen pointer's base (select 0 = stack, 1 = frame) and zeroes its displacement. It also gives that pointer the epoch counter plus one, and advances the counter. The write applies before the same cycle's operations.
- R9: Each access reports its base selector (1 = frame pointer), the base value and the epoch that pointer held when the slot was applied.
- R10: Independence bit 0 covers slots 0 and 1, bit 1 covers slots 0 and 2, and bit 2 covers slots 1 and 2. A bit is 1 only when both accesses are valid and have equal epochs, and the byte ranges [disp, disp+size) do not overlap, compared as signed values.
- R11: A slot whose valid bit is low, and kind 0 in any slot, produce no access and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | NSLOT | Per-slot valid |
| opKind | input | 3*NSLOT | Per-slot operation kind, slot i at bits [3i+2:3i] |
| opSize | input | 2*NSLOT | Per-slot data size code |
| opImm | input | DW*NSLOT | Per-slot signed immediate |
| wrEn | input | 1 | Resync write strobe |
| wrFp | input | 1 | Resync target, 1 = frame pointer |
| wrData | input | AW | Resync base value |
| accValid | output | NSLOT | Access valid per slot |
| accUseFp | output | NSLOT | Access base selector, 1 = frame pointer |
| accBase | output | AW*NSLOT | Accelerated base value per slot |
| accDisp | output | DW*NSLOT | Accumulated displacement per slot |
| accSize | output | 2*NSLOT | Size code per slot |
| accEpoch | output | EW*NSLOT | Base epoch per slot |
| pairIndep | output | NSLOT*(NSLOT-1)/2 | Pairwise independence flags |

## Verification
The bench builds the block with three slots, a 32-bit base, a 16-bit displacement and a 4-bit epoch. The sweep covers all 512 kind combinations across the three slots, with rotating size codes, immediates and valid masks, and with resync writes to either pointer interleaved. This reaches every ordering of pushes, pops, adjusts and copies inside one cycle. Because the epoch is small, epoch wraparound also falls inside the run. Directed cycles pin down overlapping and disjoint ranges, write-before-ops ordering and the copy moves between the two pointers.

// File: rtl/stkAccPkg.sv
package stkAccPkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_SPMEM = 3'd3,
    OP_FPMEM = 3'd4,
    OP_SPADJ = 3'd5,
    OP_SP2FP = 3'd6,
    OP_FP2SP = 3'd7
  } stkOp_e;

  // Per-slot strobes from control to datapath
  typedef struct packed {
    logic access;   // slot produces a memory access
    logic useFp;    // access is frame-pointer based
    logic preDec;   // lower stack disp, access at new value
    logic postInc;  // access at old value, raise stack disp
    logic offset;   // access at pointer disp + immediate
    logic adjust;   // stack disp += immediate
    logic sp2fp;    // frame pointer takes stack pointer state
    logic fp2sp;    // stack pointer takes frame pointer state
  } slotStrobe_t;

  typedef struct packed {
    logic loadSp;
    logic loadFp;
  } baseStrobe_t;

  function automatic logic [3:0] sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    sizeBytes = 4'd2;
      2'd1:    sizeBytes = 4'd4;
      default: sizeBytes = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/stkAccCtrl.sv
module stkAccCtrl
  import stkAccPkg::*;
#(
  parameter int NSLOT = 3
) (
  input  logic [NSLOT-1:0]               opValid,
  input  logic [NSLOT*3-1:0]             opKind,
  input  logic                           wrEn,
  input  logic                           wrFp,
  output slotStrobe_t [NSLOT-1:0]        slotStb,
  output baseStrobe_t                    baseStb
);

  always_comb begin
    baseStb.loadSp = wrEn && !wrFp;
    baseStb.loadFp = wrEn && wrFp;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    stkOp_e kind;
    assign kind = stkOp_e'(opKind[i*3 +: 3]);

    always_comb begin
      slotStb[i] = '0;
      if (opValid[i]) begin
        case (kind)
          OP_PUSH: begin
            slotStb[i].access = 1'b1;
            slotStb[i].preDec = 1'b1;
          end
          OP_POP: begin
            slotStb[i].access  = 1'b1;
            slotStb[i].postInc = 1'b1;
          end
          OP_SPMEM: begin
            slotStb[i].access = 1'b1;
            slotStb[i].offset = 1'b1;
          end
          OP_FPMEM: begin
            slotStb[i].access = 1'b1;
            slotStb[i].offset = 1'b1;
            slotStb[i].useFp  = 1'b1;
          end
          OP_SPADJ: slotStb[i].adjust = 1'b1;
          OP_SP2FP: slotStb[i].sp2fp  = 1'b1;
          OP_FP2SP: slotStb[i].fp2sp  = 1'b1;
          default:  slotStb[i] = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/stkAccDatapath.sv
module stkAccDatapath
  import stkAccPkg::*;
#(
  parameter int NSLOT = 3,
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int EW    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  slotStrobe_t [NSLOT-1:0]   slotStb,
  input  baseStrobe_t               baseStb,
  input  logic [NSLOT-1:0]          opValid,
  input  logic [NSLOT*2-1:0]        opSize,
  input  logic [NSLOT*DW-1:0]       opImm,
  input  logic [AW-1:0]             wrData,
  output logic [NSLOT-1:0]          accValid,
  output logic [NSLOT-1:0]          accUseFp,
  output logic [NSLOT*AW-1:0]       accBase,
  output logic [NSLOT*DW-1:0]       accDisp,
  output logic [NSLOT*2-1:0]        accSize,
  output logic [NSLOT*EW-1:0]       accEpoch
);

  localparam int PADW = DW - 4;

  // Architectural accelerated state
  logic [AW-1:0] spBase, fpBase;
  logic [DW-1:0] spDisp, fpDisp;
  logic [EW-1:0] spEpoch, fpEpoch, epochCtr;

  // Working chain through the slots
  logic [AW-1:0] wSpB, wFpB;
  logic [DW-1:0] wSpD, wFpD;
  logic [EW-1:0] wSpE, wFpE, newEpoch;
  logic [DW-1:0] imm, bytes;

  logic [DW-1:0] stepDisp  [NSLOT];
  logic [AW-1:0] stepBase  [NSLOT];
  logic [EW-1:0] stepEpoch [NSLOT];

  always_comb begin
    newEpoch = epochCtr + 1'b1;
    wSpB = spBase;  wSpD = spDisp;  wSpE = spEpoch;
    wFpB = fpBase;  wFpD = fpDisp;  wFpE = fpEpoch;
    imm   = '0;
    bytes = '0;
    // Resync write is older than any op of this cycle
    if (baseStb.loadSp) begin
      wSpB = wrData;
      wSpD = '0;
      wSpE = newEpoch;
    end
    if (baseStb.loadFp) begin
      wFpB = wrData;
      wFpD = '0;
      wFpE = newEpoch;
    end
    for (int i = 0; i < NSLOT; i++) begin
      imm   = opImm[i*DW +: DW];
      bytes = {{PADW{1'b0}}, sizeBytes(opSize[i*2 +: 2])};
      stepDisp[i] = wSpD;
      if (slotStb[i].preDec) begin
        wSpD        = wSpD - bytes;
        stepDisp[i] = wSpD;
      end else if (slotStb[i].postInc) begin
        stepDisp[i] = wSpD;
        wSpD        = wSpD + bytes;
      end else if (slotStb[i].offset) begin
        stepDisp[i] = (slotStb[i].useFp ? wFpD : wSpD) + imm;
      end else if (slotStb[i].adjust) begin
        wSpD = wSpD + imm;
      end else if (slotStb[i].sp2fp) begin
        wFpB = wSpB;
        wFpD = wSpD;
        wFpE = wSpE;
      end else if (slotStb[i].fp2sp) begin
        wSpB = wFpB;
        wSpD = wFpD;
        wSpE = wFpE;
      end
      stepBase[i]  = slotStb[i].useFp ? wFpB : wSpB;
      stepEpoch[i] = slotStb[i].useFp ? wFpE : wSpE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spBase   <= '0;
      fpBase   <= '0;
      spDisp   <= '0;
      fpDisp   <= '0;
      spEpoch  <= '0;
      fpEpoch  <= '0;
      epochCtr <= '0;
    end else begin
      spBase  <= wSpB;
      fpBase  <= wFpB;
      spDisp  <= wSpD;
      fpDisp  <= wFpD;
      spEpoch <= wSpE;
      fpEpoch <= wFpE;
      if (baseStb.loadSp || baseStb.loadFp) epochCtr <= newEpoch;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN) begin
        accValid[i]              <= 1'b0;
        accUseFp[i]              <= 1'b0;
        accBase[i*AW +: AW]      <= '0;
        accDisp[i*DW +: DW]      <= '0;
        accSize[i*2 +: 2]        <= '0;
        accEpoch[i*EW +: EW]     <= '0;
      end else begin
        accValid[i]              <= slotStb[i].access;
        accUseFp[i]              <= slotStb[i].useFp;
        accBase[i*AW +: AW]      <= stepBase[i];
        accDisp[i*DW +: DW]      <= stepDisp[i];
        accSize[i*2 +: 2]        <= opSize[i*2 +: 2];
        accEpoch[i*EW +: EW]     <= stepEpoch[i];
      end
    end

    // An access can only come from a slot that was valid one cycle earlier
    assert_acc_from_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
      accValid[i] |-> $past(opValid[i]));
  end

  // Idle cycle leaves both pointers untouched
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid == '0 && !baseStb.loadSp && !baseStb.loadFp) |=>
      ($stable(spDisp) && $stable(fpDisp) && $stable(spBase) && $stable(fpBase)));

  // Resync of the stack pointer alone zeroes its displacement and loads the base
  assert_resync_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (baseStb.loadSp && opValid == '0) |=> (spDisp == '0 && spBase == $past(wrData)));

  // Each resync advances the epoch counter by exactly one
  assert_epoch_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (baseStb.loadSp || baseStb.loadFp) |=> (epochCtr == $past(epochCtr) + 1'b1));

  // A lone push in slot 0 lowers the stack displacement by its size
  assert_push_lowers_R2: assert property (@(posedge clk) disable iff (!rstN)
    (slotStb[0].preDec && opValid[NSLOT-1:1] == '0 && !baseStb.loadSp && !baseStb.loadFp) |=>
      (spDisp == $past(spDisp) - {{PADW{1'b0}}, sizeBytes($past(opSize[1:0]))}));

endmodule

// File: rtl/stkAccOverlap.sv
module stkAccOverlap
  import stkAccPkg::*;
#(
  parameter int NSLOT = 3,
  parameter int DW    = 16,
  parameter int EW    = 4,
  localparam int NPAIR = NSLOT * (NSLOT - 1) / 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSLOT-1:0]       accValid,
  input  logic [NSLOT*DW-1:0]    accDisp,
  input  logic [NSLOT*2-1:0]     accSize,
  input  logic [NSLOT*EW-1:0]    accEpoch,
  output logic [NPAIR-1:0]       pairIndep
);

  for (genvar a = 0; a < NSLOT; a++) begin : g_a
    for (genvar b = a + 1; b < NSLOT; b++) begin : g_b
      localparam int P = a * NSLOT - (a * (a + 1)) / 2 + (b - a - 1);
      logic signed [DW:0] loA, loB, hiA, hiB;
      logic sameEpoch, disjoint;

      always_comb begin
        loA = $signed({accDisp[a*DW + DW - 1], accDisp[a*DW +: DW]});
        loB = $signed({accDisp[b*DW + DW - 1], accDisp[b*DW +: DW]});
        hiA = loA + $signed({{(DW-4){1'b0}}, 1'b0, sizeBytes(accSize[a*2 +: 2])});
        hiB = loB + $signed({{(DW-4){1'b0}}, 1'b0, sizeBytes(accSize[b*2 +: 2])});
        sameEpoch = accEpoch[a*EW +: EW] == accEpoch[b*EW +: EW];
        disjoint  = (hiA <= loB) || (hiB <= loA);
        pairIndep[P] = accValid[a] && accValid[b] && sameEpoch && disjoint;
      end

      // Independent accesses can never share a start displacement
      assert_indep_distinct_R10: assert property (@(posedge clk) disable iff (!rstN)
        pairIndep[P] |-> (accDisp[a*DW +: DW] != accDisp[b*DW +: DW]));
    end
  end

endmodule

// File: rtl/stack_disp_accum.sv
module stack_disp_accum
  import stkAccPkg::*;
#(
  parameter int NSLOT = 3,
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int EW    = 4,
  localparam int NPAIR = NSLOT * (NSLOT - 1) / 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSLOT-1:0]       opValid,
  input  logic [NSLOT*3-1:0]     opKind,
  input  logic [NSLOT*2-1:0]     opSize,
  input  logic [NSLOT*DW-1:0]    opImm,
  input  logic                   wrEn,
  input  logic                   wrFp,
  input  logic [AW-1:0]          wrData,
  output logic [NSLOT-1:0]       accValid,
  output logic [NSLOT-1:0]       accUseFp,
  output logic [NSLOT*AW-1:0]    accBase,
  output logic [NSLOT*DW-1:0]    accDisp,
  output logic [NSLOT*2-1:0]     accSize,
  output logic [NSLOT*EW-1:0]    accEpoch,
  output logic [NPAIR-1:0]       pairIndep
);

  slotStrobe_t [NSLOT-1:0] slotStb;
  baseStrobe_t             baseStb;

  stkAccCtrl #(.NSLOT(NSLOT)) u_ctrl (
    .opValid (opValid),
    .opKind  (opKind),
    .wrEn    (wrEn),
    .wrFp    (wrFp),
    .slotStb (slotStb),
    .baseStb (baseStb)
  );

  stkAccDatapath #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .EW(EW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .slotStb  (slotStb),
    .baseStb  (baseStb),
    .opValid  (opValid),
    .opSize   (opSize),
    .opImm    (opImm),
    .wrData   (wrData),
    .accValid (accValid),
    .accUseFp (accUseFp),
    .accBase  (accBase),
    .accDisp  (accDisp),
    .accSize  (accSize),
    .accEpoch (accEpoch)
  );

  stkAccOverlap #(.NSLOT(NSLOT), .DW(DW), .EW(EW)) u_ovl (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accDisp   (accDisp),
    .accSize   (accSize),
    .accEpoch  (accEpoch),
    .pairIndep (pairIndep)
  );

endmodule

// File: tb/tb_stack_disp_accum.sv
`timescale 1ns/1ps
module tb_stack_disp_accum;

  localparam int NSLOT = 3;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int EW = 4;
  localparam int NPAIR = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSLOT-1:0]    opValid = '0;
  logic [NSLOT*3-1:0]  opKind = '0;
  logic [NSLOT*2-1:0]  opSize = '0;
  logic [NSLOT*DW-1:0] opImm = '0;
  logic wrEn = 1'b0, wrFp = 1'b0;
  logic [AW-1:0] wrData = '0;
  logic [NSLOT-1:0]    accValid, accUseFp;
  logic [NSLOT*AW-1:0] accBase;
  logic [NSLOT*DW-1:0] accDisp;
  logic [NSLOT*2-1:0]  accSize;
  logic [NSLOT*EW-1:0] accEpoch;
  logic [NPAIR-1:0]    pairIndep;

  always #2 clk = ~clk;

  stack_disp_accum #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .EW(EW)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opSize(opSize),
    .opImm(opImm), .wrEn(wrEn), .wrFp(wrFp), .wrData(wrData),
    .accValid(accValid), .accUseFp(accUseFp), .accBase(accBase), .accDisp(accDisp),
    .accSize(accSize), .accEpoch(accEpoch), .pairIndep(pairIndep)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string ovTag = "";

  // Reference state, built from the requirements
  logic [AW-1:0] mSpB, mFpB;
  logic [DW-1:0] mSpD, mFpD;
  logic [EW-1:0] mSpE, mFpE, mCtr;

  // Expected outputs of the ops most recently applied
  bit            havePend = 1'b0;
  logic          pValid [NSLOT];
  logic          pUseFp [NSLOT];
  logic [AW-1:0] pBase  [NSLOT];
  logic [DW-1:0] pDisp  [NSLOT];
  logic [1:0]    pSize  [NSLOT];
  logic [EW-1:0] pEpoch [NSLOT];
  logic [2:0]    pKind  [NSLOT];

  function automatic int bytesOf(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    string t;
    t = (ovTag != "") ? ovTag : tag;
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mSpB = '0; mFpB = '0; mSpD = '0; mFpD = '0;
    mSpE = '0; mFpE = '0; mCtr = '0;
  endtask

  task automatic modelStep();
    logic [DW-1:0] imm, by;
    if (wrEn) begin
      mCtr = mCtr + 1'b1;
      if (wrFp) begin mFpB = wrData; mFpD = '0; mFpE = mCtr; end
      else      begin mSpB = wrData; mSpD = '0; mSpE = mCtr; end
    end
    for (int i = 0; i < NSLOT; i++) begin
      imm = opImm[i*DW +: DW];
      by  = DW'(bytesOf(opSize[i*2 +: 2]));
      pValid[i] = 1'b0; pUseFp[i] = 1'b0; pDisp[i] = '0;
      pKind[i]  = opKind[i*3 +: 3];
      pSize[i]  = opSize[i*2 +: 2];
      if (opValid[i]) begin
        case (opKind[i*3 +: 3])
          3'd1: begin mSpD = mSpD - by; pValid[i] = 1'b1; pDisp[i] = mSpD; end
          3'd2: begin pValid[i] = 1'b1; pDisp[i] = mSpD; mSpD = mSpD + by; end
          3'd3: begin pValid[i] = 1'b1; pDisp[i] = mSpD + imm; end
          3'd4: begin pValid[i] = 1'b1; pUseFp[i] = 1'b1; pDisp[i] = mFpD + imm; end
          3'd5: mSpD = mSpD + imm;
          3'd6: begin mFpB = mSpB; mFpD = mSpD; mFpE = mSpE; end
          3'd7: begin mSpB = mFpB; mSpD = mFpD; mSpE = mFpE; end
          default: ;
        endcase
      end
      pBase[i]  = pUseFp[i] ? mFpB : mSpB;
      pEpoch[i] = pUseFp[i] ? mFpE : mSpE;
    end
  endtask

  task automatic comparePend();
    string dTag;
    int lo [NSLOT];
    int hi [NSLOT];
    for (int i = 0; i < NSLOT; i++) begin
      chk("R11", 64'(accValid[i]), 64'(pValid[i]));
      lo[i] = $signed(pDisp[i]);
      hi[i] = lo[i] + bytesOf(pSize[i]);
      if (pValid[i]) begin
        dTag = (pKind[i] == 3'd1) ? "R2" : (pKind[i] == 3'd2) ? "R3" : "R5";
        chk("R9", 64'(accUseFp[i]), 64'(pUseFp[i]));
        chk("R9", 64'(accBase[i*AW +: AW]), 64'(pBase[i]));
        chk(dTag, 64'(accDisp[i*DW +: DW]), 64'(pDisp[i]));
        chk("R5", 64'(accSize[i*2 +: 2]), 64'(pSize[i]));
        chk("R8", 64'(accEpoch[i*EW +: EW]), 64'(pEpoch[i]));
      end
    end
    for (int a = 0; a < NSLOT; a++) begin
      for (int b = a + 1; b < NSLOT; b++) begin
        int p;
        logic e;
        p = (a == 0) ? (b - 1) : 2;
        e = pValid[a] && pValid[b] && (pEpoch[a] == pEpoch[b]) &&
            ((hi[a] <= lo[b]) || (hi[b] <= lo[a]));
        chk("R10", 64'(pairIndep[p]), 64'(e));
      end
    end
  endtask

  task automatic cyc(input logic [2:0] v, input logic [8:0] k, input logic [5:0] s,
                     input logic [47:0] im, input logic we, input logic wf,
                     input logic [AW-1:0] wd);
    @(negedge clk);
    if (havePend) comparePend();
    opValid = v; opKind = k; opSize = s; opImm = im;
    wrEn = we; wrFp = wf; wrData = wd;
    modelStep();
    havePend = 1'b1;
  endtask

  task automatic flush();
    cyc(3'b000, '0, '0, '0, 1'b0, 1'b0, '0);
    @(negedge clk);
    comparePend();
    havePend = 1'b0;
  endtask

  function automatic logic [47:0] imms(input int a, input int b, input int c);
    return {16'(c), 16'(b), 16'(a)};
  endfunction

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: nothing valid and no independence after reset
    chk("R1", 64'(accValid), 64'd0);
    chk("R1", 64'(pairIndep), 64'd0);

    // R1: first push after reset uses base 0, epoch 0, disp -2
    ovTag = "R1";
    cyc(3'b001, {3'd0, 3'd0, 3'd1}, 6'b000000, '0, 1'b0, 1'b0, '0);
    flush();

    // R4: three pushes in one cycle accumulate in slot order; all pairs disjoint
    ovTag = "R4";
    cyc(3'b111, {3'd1, 3'd1, 3'd1}, {2'd2, 2'd1, 2'd0}, '0, 1'b0, 1'b0, '0);
    cyc(3'b111, {3'd2, 3'd2, 3'd2}, {2'd0, 2'd1, 2'd2}, '0, 1'b0, 1'b0, '0);
    flush();

    // R6: adjust then pops see the moved displacement; adjust itself is silent
    ovTag = "R6";
    cyc(3'b111, {3'd2, 3'd2, 3'd5}, {2'd1, 2'd0, 2'd0}, imms(32, 0, 0), 1'b0, 1'b0, '0);
    cyc(3'b001, {3'd0, 3'd0, 3'd5}, 6'd0, imms(-40, 0, 0), 1'b0, 1'b0, '0);
    flush();

    // R7: copies between the pointers carry base, disp and epoch
    ovTag = "R7";
    cyc(3'b111, {3'd4, 3'd6, 3'd1}, {2'd2, 2'd0, 2'd2}, imms(0, 0, 0), 1'b1, 1'b0, 32'h1000);
    cyc(3'b111, {3'd1, 3'd4, 3'd7}, {2'd1, 2'd1, 2'd0}, imms(0, 8, 0), 1'b1, 1'b1, 32'h2000);
    flush();

    // R8: resync of the frame pointer applies before same-cycle frame accesses
    ovTag = "R8";
    cyc(3'b111, {3'd3, 3'd4, 3'd4}, {2'd2, 2'd1, 2'd1}, imms(-8, 4, 0), 1'b1, 1'b1, 32'h3300);
    flush();

    // R10: overlapping vs disjoint ranges on the same base
    ovTag = "R10";
    cyc(3'b111, {3'd3, 3'd3, 3'd3}, {2'd0, 2'd0, 2'd2}, imms(0, 4, 6), 1'b0, 1'b0, '0);
    cyc(3'b111, {3'd3, 3'd3, 3'd3}, {2'd2, 2'd2, 2'd1}, imms(0, 8, -4), 1'b0, 1'b0, '0);
    cyc(3'b011, {3'd0, 3'd4, 3'd3}, {2'd0, 2'd2, 2'd2}, imms(0, 16, 0), 1'b0, 1'b0, '0);
    flush();

    // R11: invalid pushes change nothing; a pop afterwards reveals the displacement
    ovTag = "R11";
    cyc(3'b000, {3'd1, 3'd1, 3'd5}, {2'd2, 2'd2, 2'd2}, imms(100, 100, 100), 1'b0, 1'b0, '0);
    cyc(3'b001, {3'd0, 3'd0, 3'd2}, 6'd0, '0, 1'b0, 1'b0, '0);
    flush();

    // Sweep over all kind triples with rotating sizes, immediates, masks and resyncs
    ovTag = "";
    for (int k = 0; k < 512; k++) begin
      logic [2:0] v;
      v = (k % 5 == 4) ? 3'((k >> 3) & 7) : 3'b111;
      cyc(v, 9'(k), 6'((k * 7) % 64),
          imms(((k * 13) % 32) * 2 - 32, ((k * 13 + 29) % 32) * 2 - 32, ((k * 5 + 7) % 32) * 2 - 32),
          (k % 23 == 0), (k % 46 == 0), 32'(k * 16 + 32'h8000));
    end
    flush();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule